// File: doc/BRIEF.md
# Descriptor-Queue Transmit DMA Channel

This block is a single-direction packet DMA channel. Software builds buffer descriptors in a small internal descriptor RAM and places packet bytes in a small internal data RAM, both through one word-wide register port. Writing a descriptor address to the head register starts the engine. The engine walks the linked descriptor list and emits each buffer as a byte stream with valid/ready handshaking and start/end-of-packet markers. After each buffer it writes status back into the descriptor and queues that descriptor's address as a completion.

Software hands each descriptor to the engine by setting its owner flag, and gets it back when the engine clears that flag. A descriptor whose next link is zero is marked end-of-queue and the engine stops there. Software can then tell a finished queue from one that is still running. Each completion has to be acknowledged by writing the descriptor address to the completion register. An interrupt stays raised while acknowledgements are outstanding, and an out-of-order acknowledgement latches an error flag.

Register map, by byte address on an 8-bit port:
- `0x00`: enable.
- `0x04`: head.
- `0x08`: completion.
- `0x0C`: soft reset.
- `0x40`–`0x7F`: descriptor RAM. There are 4 descriptors of 16 bytes each, so a descriptor address of zero never points at a descriptor.
- `0x80`–`0xFF`: data RAM, 32 words. Bytes are little-endian within a word.

Top module: `dq_tx_channel`

## Requirements
- R1: After reset the stream is idle (`tx_valid_o`=0), `irq_o`=0, `err_o`=0, and the enable, head, completion and soft-reset registers all read 0.
- R2: A descriptor is four words at byte offsets 0, 4, 8 and 12, holding next pointer, buffer byte offset in data RAM, buffer length (bits 10:0) and mode word. Mode bits are: 31 start-of-packet, 30 end-of-packet, 29 owner, 28 end-of-queue. Writing a nonzero address to the head register while enabled and idle starts processing at that descriptor.
- R3: For each owned descriptor the stream carries `length` bytes from the data RAM, starting at the buffer offset and wrapping modulo the data RAM size. `tx_sop_o` is on the first byte only if mode bit 31 is set, and `tx_eop_o` is on the last byte only if mode bit 30 is set. Outputs hold while `tx_ready_i` is low. A length of 0 emits no byte but is still written back.
- R4: Writeback clears owner (bit 29), sets end-of-queue (bit 28) exactly when the next pointer is zero, and leaves every other mode bit unchanged.
- R5: The next pointer is read after the buffer has been sent, so a link patched into a running queue is followed.
- R6: A descriptor fetched without its owner bit ends processing. No byte is sent, the descriptor is not modified and no completion is queued.
- R7: `irq_o` is 1 exactly while completed descriptors remain unacknowledged.
- R8: A completion write equal to the oldest unacknowledged descriptor address retires it, and the completion register then reads that address. Any other value retires nothing and sets the sticky `err_o`.
- R9: Writing 1 to soft reset makes bit 0 read 1 for 8 cycles, after which it reads 0. The reset stops the engine and clears enable, the completion queue and `err_o`.
- R10: A head write is ignored while the channel is disabled or busy. While busy the head register reads the descriptor in progress; while idle it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register port write strobe |
| reg_addr_i | input | 8 | Register port byte address |
| reg_wdata_i | input | 32 | Register port write data |
| reg_rdata_o | output | 32 | Register port read data (combinational) |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink ready |
| tx_data_o | output | 8 | Stream byte |
| tx_sop_o | output | 1 | First byte of packet |
| tx_eop_o | output | 1 | Last byte of packet |
| irq_o | output | 1 | Unacknowledged completions pending |
| err_o | output | 1 | Sticky acknowledgement-order error |

## Verification
The assertions assume that software does not rewrite data RAM words that lie under a buffer being streamed, so held stream bytes stay stable. They also assume every head and next pointer is zero or the 16-byte-aligned address of a descriptor inside the descriptor window. The stimulus keeps to both rules: it loads the data RAM once before any transfer and only ever links descriptors at 0x40, 0x50, 0x60 and 0x70. Descriptor words are patched during a run only on a descriptor that the engine has not yet reached.

// File: rtl/dq_pkg.sv
`timescale 1ns/1ps
package dq_pkg;
  localparam int MODE_SOP = 31;
  localparam int MODE_EOP = 30;
  localparam int MODE_OWN = 29;
  localparam int MODE_EOQ = 28;
  localparam int LEN_W    = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SEND, ST_WB} eng_st_e;
endpackage

// File: rtl/dq_desc_ram.sv
`timescale 1ns/1ps
module dq_desc_ram #(
  parameter int ENTRIES = 4
) (
  input  logic                     clk_i,
  input  logic                     sw_we_i,
  input  logic [$clog2(ENTRIES*4)-1:0] sw_widx_i,
  input  logic [31:0]              sw_wdata_i,
  input  logic [$clog2(ENTRIES*4)-1:0] sw_ridx_i,
  output logic [31:0]              sw_rdata_o,
  input  logic [((ENTRIES>1)?$clog2(ENTRIES):1)-1:0] eng_idx_i,
  output logic [3:0][31:0]         eng_words_o,
  input  logic                     eng_we_i,
  input  logic [31:0]              eng_wdata_i
);
  localparam int WORDS = ENTRIES * 4;
  localparam int WI_W  = $clog2(WORDS);

  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (sw_we_i) mem_q[sw_widx_i] <= sw_wdata_i;
    else if (eng_we_i) mem_q[WI_W'({eng_idx_i, 2'd3})] <= eng_wdata_i;
  end

  assign sw_rdata_o = mem_q[sw_ridx_i];

  for (genvar w = 0; w < 4; w++) begin : g_word
    assign eng_words_o[w] = mem_q[WI_W'({eng_idx_i, w[1:0]})];
  end
endmodule

// File: rtl/dq_data_ram.sv
`timescale 1ns/1ps
module dq_data_ram #(
  parameter int WORDS = 32
) (
  input  logic                     clk_i,
  input  logic                     sw_we_i,
  input  logic [$clog2(WORDS)-1:0] sw_widx_i,
  input  logic [31:0]              sw_wdata_i,
  input  logic [$clog2(WORDS)-1:0] sw_ridx_i,
  output logic [31:0]              sw_rdata_o,
  input  logic [$clog2(WORDS)-1:0] eng_ridx_i,
  output logic [31:0]              eng_rdata_o
);
  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (sw_we_i) mem_q[sw_widx_i] <= sw_wdata_i;
  end

  assign sw_rdata_o  = mem_q[sw_ridx_i];
  assign eng_rdata_o = mem_q[eng_ridx_i];
endmodule

// File: rtl/dq_engine.sv
`timescale 1ns/1ps
module dq_engine import dq_pkg::*; #(
  parameter int ADDR_W  = 8,
  parameter int ENT_W   = 2,
  parameter int DATA_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_ptr_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_ptr_o,
  output logic [ENT_W-1:0]  desc_idx_o,
  input  logic [3:0][31:0]  desc_words_i,
  input  logic              stall_i,
  output logic              wb_we_o,
  output logic [31:0]       wb_data_o,
  input  logic              cpl_full_i,
  output logic              cpl_push_o,
  output logic [ADDR_W-1:0] cpl_ptr_o,
  output logic [DATA_AW-1:0] dat_widx_o,
  input  logic [31:0]       dat_word_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_sop_o,
  output logic              tx_eop_o,
  input  logic              tx_ready_i
);
  localparam int DATA_BW = DATA_AW + 2;

  eng_st_e            st_q;
  logic [ADDR_W-1:0]  cur_q;
  logic [DATA_BW-1:0] buf_q;
  logic [LEN_W-1:0]   len_q, cnt_q;
  logic               sop_q, eop_q;

  logic [31:0]        mode;
  logic               next_nz, last, wb_go;
  logic [DATA_BW-1:0] byte_addr;

  assign mode      = desc_words_i[3];
  assign next_nz   = |desc_words_i[0];
  assign byte_addr = buf_q + cnt_q[DATA_BW-1:0];
  assign last      = (cnt_q == len_q - 1'b1);
  assign wb_go     = (st_q == ST_WB) && !stall_i && !cpl_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
      buf_q <= '0;
      len_q <= '0;
      cnt_q <= '0;
      sop_q <= 1'b0;
      eop_q <= 1'b0;
    end else if (srst_i) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          cur_q <= start_ptr_i;
          st_q  <= ST_FETCH;
        end
        ST_FETCH: begin
          if (!mode[MODE_OWN]) st_q <= ST_IDLE;
          else begin
            buf_q <= desc_words_i[1][DATA_BW-1:0];
            len_q <= desc_words_i[2][LEN_W-1:0];
            sop_q <= mode[MODE_SOP];
            eop_q <= mode[MODE_EOP];
            cnt_q <= '0;
            st_q  <= (desc_words_i[2][LEN_W-1:0] == '0) ? ST_WB : ST_SEND;
          end
        end
        ST_SEND: if (tx_ready_i) begin
          if (last) st_q <= ST_WB;
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_WB: if (wb_go) begin
          if (next_nz) begin
            cur_q <= desc_words_i[0][ADDR_W-1:0];
            st_q  <= ST_FETCH;
          end else st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wb_data_o           = mode;
    wb_data_o[MODE_OWN] = 1'b0;
    wb_data_o[MODE_EOQ] = !next_nz;
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign cur_ptr_o  = cur_q;
  assign desc_idx_o = cur_q[ENT_W+3:4];
  assign wb_we_o    = wb_go;
  assign cpl_push_o = wb_go;
  assign cpl_ptr_o  = cur_q;
  assign dat_widx_o = byte_addr[DATA_BW-1:2];
  assign tx_valid_o = (st_q == ST_SEND);
  assign tx_data_o  = dat_word_i[{byte_addr[1:0], 3'b000} +: 8];
  assign tx_sop_o   = tx_valid_o && sop_q && (cnt_q == '0);
  assign tx_eop_o   = tx_valid_o && eop_q && last;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || srst_i)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) &&
                                  $stable(tx_sop_o) && $stable(tx_eop_o));
endmodule

// File: rtl/dq_cpl_fifo.sv
`timescale 1ns/1ps
module dq_cpl_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_ptr_i,
  input  logic          ack_i,
  input  logic [AW-1:0] ack_ptr_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          err_o,
  output logic [AW-1:0] last_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          ack_ok, ack_bad, push_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign ack_ok  = ack_i && !empty_o && (ack_ptr_i == mem_q[rp_q]);
  assign ack_bad = ack_i && !ack_ok;
  assign push_ok = push_i && !full_o;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; err_o <= 1'b0; last_o <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; err_o <= 1'b0; last_o <= '0;
    end else begin
      if (push_ok) wp_q <= bump(wp_q);
      if (ack_ok) begin
        rp_q   <= bump(rp_q);
        last_o <= ack_ptr_i;
      end
      if (ack_bad) err_o <= 1'b1;
      cnt_q <= cnt_q + CW'(push_ok) - CW'(ack_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= push_ptr_i;
  end

  assert_push_room_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !flush_i |=> !empty_o);
  assert_err_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(ack_i));
endmodule

// File: rtl/dq_tx_channel.sv
`timescale 1ns/1ps
module dq_tx_channel #(
  parameter int ADDR_W      = 8,
  parameter int DESC_NUM    = 4,
  parameter int DATA_WORDS  = 32,
  parameter int SRST_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_sop_o,
  output logic              tx_eop_o,
  output logic              irq_o,
  output logic              err_o
);
  localparam int DW_IDX  = $clog2(DESC_NUM * 4);
  localparam int ENT_W   = (DESC_NUM > 1) ? $clog2(DESC_NUM) : 1;
  localparam int DATA_AW = $clog2(DATA_WORDS);
  localparam int SRST_W  = $clog2(SRST_CYCLES + 1);

  logic is_ctl, is_desc, is_data;
  logic [1:0] ctl_sel;
  assign is_ctl  = (reg_addr_i[ADDR_W-1:ADDR_W-2] == 2'b00);
  assign is_desc = (reg_addr_i[ADDR_W-1:ADDR_W-2] == 2'b01);
  assign is_data = reg_addr_i[ADDR_W-1];
  assign ctl_sel = reg_addr_i[3:2];

  logic              en_q, srst_busy, busy, cpl_empty, cpl_full;
  logic [SRST_W-1:0] srst_cnt_q;
  logic              start, ack, desc_we, eng_wb_we, cpl_push;
  logic [ADDR_W-1:0] cur_ptr, cpl_ptr, last_ack;
  logic [ENT_W-1:0]  desc_idx;
  logic [3:0][31:0]  desc_words;
  logic [31:0]       wb_data, desc_rdata, data_rdata, dat_word;
  logic [DATA_AW-1:0] dat_widx;

  assign srst_busy = (srst_cnt_q != '0);
  assign desc_we   = reg_we_i && is_desc;
  assign start     = reg_we_i && is_ctl && (ctl_sel == 2'd1) && en_q && !busy &&
                     !srst_busy && (reg_wdata_i[ADDR_W-1:0] != '0);
  assign ack       = reg_we_i && is_ctl && (ctl_sel == 2'd2) && !srst_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      srst_cnt_q <= '0;
    end else begin
      if (srst_busy) srst_cnt_q <= srst_cnt_q - 1'b1;
      else if (reg_we_i && is_ctl && ctl_sel == 2'd3 && reg_wdata_i[0])
        srst_cnt_q <= SRST_W'(SRST_CYCLES);
      if (srst_busy) en_q <= 1'b0;
      else if (reg_we_i && is_ctl && ctl_sel == 2'd0) en_q <= reg_wdata_i[0];
    end
  end

  dq_desc_ram #(.ENTRIES(DESC_NUM)) u_desc (
    .clk_i       (clk_i),
    .sw_we_i     (desc_we),
    .sw_widx_i   (reg_addr_i[DW_IDX+1:2]),
    .sw_wdata_i  (reg_wdata_i),
    .sw_ridx_i   (reg_addr_i[DW_IDX+1:2]),
    .sw_rdata_o  (desc_rdata),
    .eng_idx_i   (desc_idx),
    .eng_words_o (desc_words),
    .eng_we_i    (eng_wb_we),
    .eng_wdata_i (wb_data)
  );

  dq_data_ram #(.WORDS(DATA_WORDS)) u_data (
    .clk_i       (clk_i),
    .sw_we_i     (reg_we_i && is_data),
    .sw_widx_i   (reg_addr_i[DATA_AW+1:2]),
    .sw_wdata_i  (reg_wdata_i),
    .sw_ridx_i   (reg_addr_i[DATA_AW+1:2]),
    .sw_rdata_o  (data_rdata),
    .eng_ridx_i  (dat_widx),
    .eng_rdata_o (dat_word)
  );

  dq_engine #(.ADDR_W(ADDR_W), .ENT_W(ENT_W), .DATA_AW(DATA_AW)) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .srst_i       (srst_busy),
    .start_i      (start),
    .start_ptr_i  (reg_wdata_i[ADDR_W-1:0]),
    .busy_o       (busy),
    .cur_ptr_o    (cur_ptr),
    .desc_idx_o   (desc_idx),
    .desc_words_i (desc_words),
    .stall_i      (desc_we),
    .wb_we_o      (eng_wb_we),
    .wb_data_o    (wb_data),
    .cpl_full_i   (cpl_full),
    .cpl_push_o   (cpl_push),
    .cpl_ptr_o    (cpl_ptr),
    .dat_widx_o   (dat_widx),
    .dat_word_i   (dat_word),
    .tx_valid_o   (tx_valid_o),
    .tx_data_o    (tx_data_o),
    .tx_sop_o     (tx_sop_o),
    .tx_eop_o     (tx_eop_o),
    .tx_ready_i   (tx_ready_i)
  );

  dq_cpl_fifo #(.DEPTH(DESC_NUM), .AW(ADDR_W)) u_cpl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (srst_busy),
    .push_i     (cpl_push),
    .push_ptr_i (cpl_ptr),
    .ack_i      (ack),
    .ack_ptr_i  (reg_wdata_i[ADDR_W-1:0]),
    .empty_o    (cpl_empty),
    .full_o     (cpl_full),
    .err_o      (err_o),
    .last_o     (last_ack)
  );

  assign irq_o = !cpl_empty;

  always_comb begin
    reg_rdata_o = '0;
    if (is_data) reg_rdata_o = data_rdata;
    else if (is_desc) reg_rdata_o = desc_rdata;
    else begin
      unique case (ctl_sel)
        2'd0: reg_rdata_o = {31'd0, en_q};
        2'd1: reg_rdata_o = busy ? 32'(cur_ptr) : 32'd0;
        2'd2: reg_rdata_o = 32'(last_ack);
        default: reg_rdata_o = {31'd0, srst_busy};
      endcase
    end
  end

  assert_wb_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_wb_we |-> !desc_we);
  assert_srst_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_busy |=> !tx_valid_o);
endmodule

// File: tb/dq_tx_channel_test.sv
`timescale 1ns/1ps
module dq_tx_channel_test;
  localparam logic [31:0] SOP = 32'h8000_0000, EOP = 32'h4000_0000,
                          OWN = 32'h2000_0000, EOQ = 32'h1000_0000;

  logic clk = 0, rst_n = 0, reg_we = 0, tx_ready = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_valid, tx_sop, tx_eop, irq, err;
  logic [7:0] tx_data;

  int tests = 0, fails = 0;
  bit rnd_ready = 0, hold_ready = 1;
  logic [7:0] mem_b [128];
  logic [7:0] got_b[$], exp_b[$];
  logic got_s[$], got_e[$], exp_s[$], exp_e[$];

  dq_tx_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .tx_data_o(tx_data), .tx_sop_o(tx_sop),
    .tx_eop_o(tx_eop), .irq_o(irq), .err_o(err));

  always #2 clk = ~clk;

  initial forever begin
    @(posedge clk); #1;
    tx_ready = rnd_ready ? ($urandom_range(3) != 0) : hold_ready;
  end

  initial forever begin
    @(negedge clk);
    if (tx_valid && tx_ready) begin
      got_b.push_back(tx_data); got_s.push_back(tx_sop); got_e.push_back(tx_eop);
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_desc(input logic [7:0] a, input logic [31:0] nxt, bufp, len, mode);
    wr(a, nxt); wr(a + 4, bufp); wr(a + 8, len); wr(a + 12, mode);
  endtask

  function automatic logic [31:0] mode_after(input logic [31:0] m, input logic [31:0] nxt);
    return (m & ~OWN & ~EOQ) | ((nxt == 0) ? EOQ : 32'd0);
  endfunction

  task automatic add_exp(input int bufp, input int len, input logic [31:0] mode);
    for (int k = 0; k < len; k++) begin
      exp_b.push_back(mem_b[(bufp + k) & 127]);
      exp_s.push_back(k == 0 && mode[31]);
      exp_e.push_back(k == len - 1 && mode[30]);
    end
  endtask

  task automatic clear_q();
    got_b.delete(); got_s.delete(); got_e.delete();
    exp_b.delete(); exp_s.delete(); exp_e.delete();
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h04, v);
      if (v == 0) break;
    end
  endtask

  task automatic chk_stream(input string req);
    int bad = 0;
    chk({req, " length"}, got_b.size(), exp_b.size());
    for (int i = 0; i < got_b.size() && i < exp_b.size(); i++)
      if (got_b[i] !== exp_b[i] || got_s[i] !== exp_s[i] || got_e[i] !== exp_e[i]) bad++;
    chk({req, " bytes/markers mismatches"}, bad, 0);
  endtask

  initial begin
    logic [31:0] v, w;
    void'($urandom(32'h5eed_0d7a));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 err", err, 0);
    rd(8'h00, v); chk("R1 enable", v, 0);
    rd(8'h04, v); chk("R1 head", v, 0);
    rd(8'h08, v); chk("R1 completion", v, 0);
    rd(8'h0C, v); chk("R1 soft reset", v, 0);

    for (int i = 0; i < 32; i++) begin
      w = $urandom;
      wr(8'h80 + 8'(4 * i), w);
      for (int k = 0; k < 4; k++) mem_b[4 * i + k] = w[8 * k +: 8];
    end

    // R10 disabled: head ignored
    clear_q();
    set_desc(8'h40, 0, 5, 7, OWN | SOP | EOP | 7);
    wr(8'h04, 8'h40);
    repeat (20) @(negedge clk);
    rd(8'h04, v); chk("R10 head ignored while disabled", v, 0);
    chk("R10 no bytes while disabled", got_b.size(), 0);

    // R2 R3 R4 single descriptor
    wr(8'h00, 1);
    wr(8'h04, 8'h40);
    wait_idle();
    add_exp(5, 7, SOP | EOP);
    chk_stream("R3 single");
    rd(8'h4C, v); chk("R4 writeback eoq", v, mode_after(OWN | SOP | EOP | 7, 0));
    chk("R7 irq pending", irq, 1);

    // R8 wrong ack then right ack
    wr(8'h08, 8'h50);
    chk("R8 err on wrong ack", err, 1);
    chk("R8 no retire on wrong ack", irq, 1);
    wr(8'h08, 8'h40);
    chk("R7 irq cleared after ack", irq, 0);
    rd(8'h08, v); chk("R8 last acked", v, 8'h40);
    chk("R8 err sticky", err, 1);

    // R9 soft reset
    wr(8'h0C, 1);
    rd(8'h0C, v); chk("R9 busy reads 1", v, 1);
    repeat (12) @(negedge clk);
    rd(8'h0C, v); chk("R9 self clears", v, 0);
    chk("R9 err cleared", err, 0);
    rd(8'h00, v); chk("R9 enable cleared", v, 0);
    rd(8'h08, v); chk("R9 completion cleared", v, 0);
    wr(8'h00, 1);

    // R5 patch running queue, one packet over three buffers
    clear_q();
    hold_ready = 0;
    set_desc(8'h40, 8'h50, 120, 6, OWN | SOP);
    set_desc(8'h50, 0, 17, 3, OWN);
    set_desc(8'h60, 0, 40, 5, OWN | EOP);
    wr(8'h04, 8'h40);
    rd(8'h04, v); chk("R10 head reads current", v, 8'h40);
    wr(8'h50, 8'h60);
    rnd_ready = 1;
    wait_idle();
    add_exp(120, 6, SOP); add_exp(17, 3, 0); add_exp(40, 5, EOP);
    chk_stream("R5 patched chain");
    rd(8'h4C, v); chk("R4 A mode", v, mode_after(OWN | SOP, 8'h50));
    rd(8'h5C, v); chk("R5 B mode no eoq", v, mode_after(OWN, 8'h60));
    rd(8'h6C, v); chk("R4 C mode eoq", v, mode_after(OWN | EOP, 0));
    wr(8'h08, 8'h40); wr(8'h08, 8'h50);
    chk("R7 irq while one left", irq, 1);
    wr(8'h08, 8'h60);
    chk("R7 irq after all acked", irq, 0);
    chk("R8 in-order acks no err", err, 0);

    // R6 not owned
    clear_q();
    set_desc(8'h70, 0, 9, 5, SOP | EOP | 5);
    wr(8'h04, 8'h70);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R6 no bytes", got_b.size(), 0);
    rd(8'h7C, v); chk("R6 descriptor untouched", v, SOP | EOP | 5);
    chk("R6 no completion", irq, 0);

    // R10 head write while busy
    clear_q();
    rnd_ready = 0; hold_ready = 0;
    set_desc(8'h40, 0, 64, 4, OWN | SOP | EOP);
    set_desc(8'h50, 0, 0, 4, OWN | SOP | EOP);
    wr(8'h04, 8'h40);
    wr(8'h04, 8'h50);
    rd(8'h04, v); chk("R10 busy head unchanged", v, 8'h40);
    rnd_ready = 1;
    wait_idle();
    add_exp(64, 4, SOP | EOP);
    chk_stream("R10 only first sent");
    rd(8'h5C, v); chk("R10 second still owned", v, OWN | SOP | EOP);
    wr(8'h08, 8'h40);

    // random two-descriptor chains, lengths include 0
    for (int it = 0; it < 15; it++) begin
      int b0, b1, l0, l1;
      logic [31:0] m0, m1;
      clear_q();
      b0 = $urandom_range(127); b1 = $urandom_range(127);
      l0 = $urandom_range(9);   l1 = $urandom_range(9);
      m0 = OWN | ($urandom & (SOP | EOP)) | 32'(l0);
      m1 = OWN | ($urandom & (SOP | EOP)) | 32'(l1);
      set_desc(8'h40, 8'h60, b0, l0, m0);
      set_desc(8'h60, 0, b1, l1, m1);
      wr(8'h04, 8'h40);
      wait_idle();
      add_exp(b0, l0, m0); add_exp(b1, l1, m1);
      chk_stream("R3 random chain");
      rd(8'h4C, v); chk("R4 random A", v, mode_after(m0, 8'h60));
      rd(8'h6C, v); chk("R4 random B", v, mode_after(m1, 0));
      wr(8'h08, 8'h40); wr(8'h08, 8'h60);
      chk("R7 random irq clear", irq, 0);
      chk("R8 random no err", err, 0);
    end

    summary();
    $finish;
  end
endmodule